// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block is the interrupt front end of a small 8-bit processor core. It takes five hardware request lines of fixed rank: a non-maskable line, a high line that is caught on a rising edge and held, a middle line, a low line, and an external general request. It keeps a global interrupt-enable bit, which the core sets and clears with two strobes. It also keeps a three-bit mask for the high, middle and low lines. The core writes this mask with a one-byte mask word, and the same word can drive a serial output bit. A status byte is always available to the core. It reports the masks, the enable bit, the raw pending state of the three maskable lines and a serial input bit.

At each instruction boundary signalled by the core, a two-state machine looks at the eligible requests. The machine moves from IDLE to GRANT when the boundary strobe is high and a request is eligible. It always moves from GRANT back to IDLE after one cycle. On the move into GRANT, the controller records the highest-ranked eligible source and clears the enable bit. It also clears the latch of the source it accepted. During GRANT it raises a one-cycle take pulse with the source code and a 16-bit restart-style vector. The vectors sit half a slot past slot n, at stride × n + stride/2. For the external request the vector is zero, because the core obtains that opcode elsewhere.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset: `take_o` is 0, `ser_out_o` is 0, `prev_ie_o` is 0, the enable bit is 0 and all three masks are 1. `mask_rdata_o` reads 0x07 while every request line and `ser_in_i` are low.
- R2: Rank from highest to lowest is non-maskable, high, middle, low, external. `take_src_o` codes these as 4, 3, 2, 1 and 0.
- R3: `take_o` is high for exactly one cycle: the cycle after the clock edge at which `boundary_i` was sampled high with an eligible request. In that cycle `take_vec_o` is 0x0024 (code 4), 0x003C (code 3), 0x0034 (code 2), 0x002C (code 1) or 0x0000 (code 0).
- R4: `ie_set_i` sets the enable bit and `ie_clr_i` clears it; the clear wins if both are high. Accepting any request clears the enable bit. While the enable bit is 0, only the non-maskable line can be accepted.
- R5: The non-maskable line is pending only after a rising edge has been seen and while the line is still high. A line that drops before the boundary is not accepted. A line held high after it was accepted is not accepted again.
- R6: The high line latches on a rising edge and stays pending after the line drops. The latch is cleared when the high request is accepted, or by a mask word with bit 4 set. A rising edge at the same edge as that mask word wins.
- R7: The middle and low lines are level-sensitive. They are eligible only while the line is high.
- R8: A mask word with bit 3 set loads bits 2:0 into the masks: bit 2 high, bit 1 middle, bit 0 low. With bit 3 clear, the masks are unchanged. A masked line is not accepted. Neither the non-maskable line nor the external line is affected by the masks.
- R9: A mask word with bit 6 set copies bit 7 to `ser_out_o`. Otherwise `ser_out_o` holds its value.
- R10: `mask_rdata_o` reads, from bit 7 down, as follows: `ser_in_i`, high pending, middle line, low line, enable bit, high mask, middle mask, low mask.
- R11: On accepting the non-maskable request, `prev_ie_o` takes the value the enable bit had just before the acceptance.
- R12: No request is accepted without `boundary_i`. A boundary seen during GRANT is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_nmi_i | input | 1 | Non-maskable request (edge and level) |
| req_hi_i | input | 1 | High request (rising-edge latched) |
| req_mid_i | input | 1 | Middle request (level) |
| req_lo_i | input | 1 | Low request (level) |
| req_ext_i | input | 1 | External general request (level) |
| ie_set_i | input | 1 | Enable-bit set strobe |
| ie_clr_i | input | 1 | Enable-bit clear strobe |
| mask_wr_i | input | 1 | Mask word write strobe |
| mask_wdata_i | input | 8 | Mask word |
| ser_in_i | input | 1 | Serial input bit shown in the status byte |
| boundary_i | input | 1 | Instruction boundary from the core |
| take_o | output | 1 | One-cycle acceptance pulse |
| take_src_o | output | 3 | Accepted source code |
| take_vec_o | output | 16 | Restart vector of the accepted source |
| mask_rdata_o | output | 8 | Status byte |
| ser_out_o | output | 1 | Serial output bit |
| prev_ie_o | output | 1 | Enable bit saved at non-maskable acceptance |

## Verification
The bench builds the block with the default parameters: a 16-bit vector and a slot stride of 8. With these values every vector the bench expects is an exact small address it can compute on its own. A table of request patterns walks each pairing of ranks through the priority encoder and checks both the source code and the vector. Directed sequences then cover the edge-and-level rule, the sticky latch and its two clears, the mask-load gate, the serial bits and the gating by the enable bit.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int SRC_W   = 3;
    localparam int NUM_SRC = 5;

    // mask word bit positions (decoded by the core's software)
    localparam int WB_MASK_LD = 3;
    localparam int WB_HI_CLR  = 4;
    localparam int WB_SER_EN  = 6;
    localparam int WB_SER_D   = 7;

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT = 3'd0,
        SRC_LO  = 3'd1,
        SRC_MID = 3'd2,
        SRC_HI  = 3'd3,
        SRC_NMI = 3'd4
    } src_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } state_e;

    // vectors sit half a slot past slot n
    function automatic logic [31:0] slot_addr(src_e s, int stride);
        int n;
        case (s)
            SRC_NMI: n = 4;
            SRC_HI:  n = 7;
            SRC_MID: n = 6;
            SRC_LO:  n = 5;
            default: n = -1;
        endcase
        if (n < 0) return 32'd0;
        return 32'(stride * n + stride / 2);
    endfunction

endpackage

// File: rtl/irq_line_cond.sv
module irq_line_cond #(
    parameter bit STICKY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic clr_i,
    output logic pend_o
);
    logic line_q;
    logic lat;
    logic lat_nx;
    logic rise;

    assign rise = line_i & ~line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            lat    <= 1'b0;
        end else begin
            line_q <= line_i;
            lat    <= lat_nx;
        end
    end

    generate
        if (STICKY) begin : g_sticky
            // a new edge outranks a clear in the same cycle
            always_comb lat_nx = rise ? 1'b1 : (clr_i ? 1'b0 : lat);
            assign pend_o = lat;

            AST_EDGE_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
                (line_i && !line_q) |=> pend_o); // R6
            AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_o && !clr_i) |=> pend_o); // R6
        end else begin : g_edge_level
            always_comb lat_nx = (!line_i || clr_i) ? 1'b0 : (lat | rise);
            assign pend_o = lat & line_i;

            AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && line_i) |=> !pend_o); // R5
        end
    endgenerate

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_vec_pkg::*;
(
    input  logic [NUM_SRC-1:0] elig_i,
    output src_e               win_o,
    output logic               any_o
);
    // higher code = higher rank; last hit in ascending order wins
    always_comb begin
        win_o = SRC_EXT;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig_i[i]) win_o = src_e'(SRC_W'(i));
        end
    end

    assign any_o = |elig_i;

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_vec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ie_set_i,
    input  logic       ie_clr_i,
    input  logic       decide_i,
    input  logic       win_nmi_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [2:0] masks_o,
    output logic       ie_o,
    output logic       prev_ie_o,
    output logic       ser_out_o,
    output logic       hi_clr_o
);
    logic unused_wbits;
    assign unused_wbits = wdata_i[5];

    assign hi_clr_o = wr_i & wdata_i[WB_HI_CLR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masks_o   <= 3'b111;
            ie_o      <= 1'b0;
            prev_ie_o <= 1'b0;
            ser_out_o <= 1'b0;
        end else begin
            if (decide_i)      ie_o <= 1'b0;
            else if (ie_clr_i) ie_o <= 1'b0;
            else if (ie_set_i) ie_o <= 1'b1;

            if (decide_i && win_nmi_i) prev_ie_o <= ie_o;

            if (wr_i && wdata_i[WB_MASK_LD]) masks_o <= wdata_i[2:0];
            if (wr_i && wdata_i[WB_SER_EN])  ser_out_o <= wdata_i[WB_SER_D];
        end
    end

    AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && wdata_i[WB_SER_EN]) |=> $stable(ser_out_o)); // R9
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && wdata_i[WB_MASK_LD]) |=> $stable(masks_o)); // R8
    AST_IE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        decide_i |=> !ie_o); // R4

endmodule

// File: rtl/irq_sel_fsm.sv
module irq_sel_fsm
    import irq_vec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic any_i,
    input  src_e win_i,
    output logic decide_o,
    output logic take_o,
    output src_e src_o
);
    state_e state;
    state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            src_o <= SRC_EXT;
        end else begin
            state <= state_nx;
            if (decide_o) src_o <= win_i;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (boundary_i && any_i) state_nx = ST_GRANT;
            ST_GRANT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        decide_o = (state == ST_IDLE) && boundary_i && any_i;
        take_o   = (state == ST_GRANT);
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R3
    AST_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> $past(boundary_i)); // R12

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int VEC_W       = 16,
    parameter int SLOT_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_nmi_i,
    input  logic             req_hi_i,
    input  logic             req_mid_i,
    input  logic             req_lo_i,
    input  logic             req_ext_i,
    input  logic             ie_set_i,
    input  logic             ie_clr_i,
    input  logic             mask_wr_i,
    input  logic [7:0]       mask_wdata_i,
    input  logic             ser_in_i,
    input  logic             boundary_i,
    output logic             take_o,
    output logic [SRC_W-1:0] take_src_o,
    output logic [VEC_W-1:0] take_vec_o,
    output logic [7:0]       mask_rdata_o,
    output logic             ser_out_o,
    output logic             prev_ie_o
);
    logic               nmi_pend;
    logic               hi_pend;
    logic               hi_clr_wr;
    logic               decide;
    logic               any_elig;
    logic               ie;
    logic [2:0]         masks;
    logic [NUM_SRC-1:0] elig;
    src_e               win;
    src_e               src_q;

    irq_line_cond #(.STICKY(1'b0)) u_nmi_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (req_nmi_i),
        .clr_i  (decide && win == SRC_NMI),
        .pend_o (nmi_pend)
    );

    irq_line_cond #(.STICKY(1'b1)) u_hi_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (req_hi_i),
        .clr_i  ((decide && win == SRC_HI) || hi_clr_wr),
        .pend_o (hi_pend)
    );

    always_comb begin
        elig          = '0;
        elig[SRC_NMI] = nmi_pend;
        elig[SRC_HI]  = ie & hi_pend   & ~masks[2];
        elig[SRC_MID] = ie & req_mid_i & ~masks[1];
        elig[SRC_LO]  = ie & req_lo_i  & ~masks[0];
        elig[SRC_EXT] = ie & req_ext_i;
    end

    irq_prio_pick u_pick (
        .elig_i (elig),
        .win_o  (win),
        .any_o  (any_elig)
    );

    irq_mask_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ie_set_i  (ie_set_i),
        .ie_clr_i  (ie_clr_i),
        .decide_i  (decide),
        .win_nmi_i (win == SRC_NMI),
        .wr_i      (mask_wr_i),
        .wdata_i   (mask_wdata_i),
        .masks_o   (masks),
        .ie_o      (ie),
        .prev_ie_o (prev_ie_o),
        .ser_out_o (ser_out_o),
        .hi_clr_o  (hi_clr_wr)
    );

    irq_sel_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary_i),
        .any_i      (any_elig),
        .win_i      (win),
        .decide_o   (decide),
        .take_o     (take_o),
        .src_o      (src_q)
    );

    assign take_src_o   = take_o ? src_q : SRC_EXT;
    assign take_vec_o   = take_o ? VEC_W'(slot_addr(src_q, SLOT_STRIDE)) : '0;
    assign mask_rdata_o = {ser_in_i, hi_pend, req_mid_i, req_lo_i, ie, masks};

    AST_IE_OFF_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !ie); // R4
    AST_GATED_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) && !$past(ie) |-> take_src_o == SRC_NMI); // R4
    AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> take_src_o <= SRC_NMI); // R2

endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_nmi, req_hi, req_mid, req_lo, req_ext;
    logic        ie_set, ie_clr, mask_wr, ser_in, boundary;
    logic [7:0]  wdata;
    logic        take;
    logic [2:0]  take_src;
    logic [15:0] take_vec;
    logic [7:0]  rdata;
    logic        ser_out, prev_ie;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    irq_vec_ctrl #(.VEC_W(16), .SLOT_STRIDE(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_nmi_i(req_nmi), .req_hi_i(req_hi), .req_mid_i(req_mid),
        .req_lo_i(req_lo), .req_ext_i(req_ext),
        .ie_set_i(ie_set), .ie_clr_i(ie_clr),
        .mask_wr_i(mask_wr), .mask_wdata_i(wdata),
        .ser_in_i(ser_in), .boundary_i(boundary),
        .take_o(take), .take_src_o(take_src), .take_vec_o(take_vec),
        .mask_rdata_o(rdata), .ser_out_o(ser_out), .prev_ie_o(prev_ie)
    );

    // pattern {nmi,hi,mid,lo,ext} and expected source code
    localparam logic [7:0] TAB [8] = '{
        {5'b11111, 3'd4}, {5'b01111, 3'd3}, {5'b00111, 3'd2}, {5'b00011, 3'd1},
        {5'b00001, 3'd0}, {5'b10001, 3'd4}, {5'b01001, 3'd3}, {5'b00110, 3'd2}
    };

    function automatic logic [15:0] exp_vec(logic [2:0] s);
        case (s)
            3'd4: return 16'h0024;
            3'd3: return 16'h003C;
            3'd2: return 16'h0034;
            3'd1: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put_word(logic [7:0] w);
        mask_wr = 1'b1; wdata = w;
        tick();
        mask_wr = 1'b0;
    endtask

    task automatic fire();
        boundary = 1'b1;
        tick();
        boundary = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {req_nmi, req_hi, req_mid, req_lo, req_ext} = '0;
        {ie_set, ie_clr, mask_wr, ser_in, boundary} = '0;
        wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        chk("R1 take", take, 0);
        chk("R1 status", rdata, 8'h07);
        chk("R1 ser_out", ser_out, 0);
        chk("R1 prev_ie", prev_ie, 0);

        // table: R2 R3 priority and vectors
        foreach (TAB[i]) begin
            ie_set = 1'b1; mask_wr = 1'b1; wdata = 8'h18;
            {req_nmi, req_hi, req_mid, req_lo, req_ext} = TAB[i][7:3];
            tick();
            ie_set = 1'b0; mask_wr = 1'b0;
            fire();
            chk("R3 take", take, 1);
            chk("R2 src", take_src, TAB[i][2:0]);
            chk("R3 vec", take_vec, exp_vec(TAB[i][2:0]));
            chk("R4 ie cleared on accept", rdata[3], 0);
            {req_nmi, req_hi, req_mid, req_lo, req_ext} = '0;
            tick();
            chk("R3 one cycle", take, 0);
        end

        // R4: enable off blocks maskable lines
        req_lo = 1'b1;
        tick();
        fire();
        chk("R4 gated", take, 0);
        req_lo = 1'b0;

        // R12: no boundary, no acceptance
        ie_set = 1'b1; req_lo = 1'b1;
        tick();
        ie_set = 1'b0;
        tick(); tick();
        chk("R12 no boundary", take, 0);
        chk("R7 low level pending bit", rdata[4], 1);
        fire();
        chk("R12 boundary take", take, 1);
        chk("R7 low src", take_src, 1);
        req_lo = 1'b0;
        tick();

        // R5: line dropped before boundary
        req_nmi = 1'b1;
        tick();
        req_nmi = 1'b0;
        fire();
        chk("R5 dropped", take, 0);
        tick();

        // R11 with enable on, then R5 no retrigger
        ie_set = 1'b1; req_nmi = 1'b1;
        tick();
        ie_set = 1'b0;
        fire();
        chk("R5 take", take, 1);
        chk("R3 nmi vec", take_vec, 16'h0024);
        chk("R11 saved on", prev_ie, 1);
        tick();
        fire();
        chk("R5 no retrigger", take, 0);
        req_nmi = 1'b0;
        tick();

        // R11 / R4: nmi with enable off
        req_nmi = 1'b1;
        tick();
        fire();
        chk("R4 nmi ignores enable", take, 1);
        chk("R11 saved off", prev_ie, 0);
        req_nmi = 1'b0;
        tick();

        // R6 sticky high latch
        req_hi = 1'b1;
        tick();
        req_hi = 1'b0;
        tick(); tick();
        chk("R6 sticky", rdata[6], 1);
        put_word(8'h10);
        chk("R6 word clear", rdata[6], 0);
        req_hi = 1'b1;
        tick();
        req_hi = 1'b0; ie_set = 1'b1;
        tick();
        ie_set = 1'b0;
        fire();
        chk("R6 take after drop", take_src, 3);
        chk("R6 service clear", rdata[6], 0);
        tick();

        // R8 masks
        put_word(8'h0F);
        chk("R8 load", rdata[2:0], 3'b111);
        put_word(8'h02);
        chk("R8 no load", rdata[2:0], 3'b111);
        ie_set = 1'b1; req_lo = 1'b1; req_mid = 1'b1;
        tick();
        ie_set = 1'b0;
        fire();
        chk("R8 masked", take, 0);
        req_ext = 1'b1;
        fire();
        chk("R8 ext unmasked", take, 1);
        chk("R8 ext src", take_src, 0);
        chk("R3 ext vec", take_vec, 16'h0000);
        {req_lo, req_mid, req_ext} = '0;
        put_word(8'h0D);
        chk("R8 partial", rdata[2:0], 3'b101);

        // R9 serial out
        put_word(8'hC0);
        chk("R9 set", ser_out, 1);
        put_word(8'h80);
        chk("R9 hold", ser_out, 1);
        put_word(8'h40);
        chk("R9 clear", ser_out, 0);

        // R10 status layout
        ser_in = 1'b1; req_mid = 1'b1;
        tick();
        chk("R10 layout", rdata, 8'hA5);
        ser_in = 1'b0; req_mid = 1'b0;
        tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule